// File: doc/BRIEF.md
# 4B5B Transmit Code-Group Encoder

This block sits between a MAC transmit nibble interface and a 100 Mb/s line coder. It takes a 4-bit nibble, a transmit enable and a transmit error flag once per code-group period and emits one 5-bit code-group per period. It also shifts each group out one bit per clock. A small frame state machine sits in front of the lookup table. When transmit enable rises, it replaces the two leading preamble nibbles with the start-of-stream delimiter pair. When enable falls, it appends the end-of-stream delimiter pair. At all other times it fills the line with IDLE.

The single clock is the bit clock. An internal counter divides it by five. The encoder samples its inputs in the last bit period of each group. The new group appears on the parallel output, and its first bit appears on the serial output, in the next cycle. A one-cycle strobe marks that cycle. Code-groups are written here MSB first as `cg_o[4:0]`. Scrambling, NRZI and MLT-3 conversion are left to later stages.

Top module: `txenc_4b5b`

## Requirements
- R1: While a frame is active, data nibbles 0 to F map to these code-groups (`cg_o[4:0]`): 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101.
- R2: The first period with enable high emits 11000 and the next period emits 10001. Both are emitted whatever the nibble value and error flag in those two periods.
- R3: From the third period of a frame onward, each period with enable high and error low emits the R1 code of that period's nibble.
- R4: The first period with enable low after a frame of two or more periods emits 01101, and the period after it emits 00111.
- R5: Outside a frame, and after the 00111 group, every period emits IDLE 11111 until enable is sampled high again. Enable sampled high in the period that follows 00111 starts a new frame at once.
- R6: A period in the data phase with both enable and error high emits HALT 00100 instead of the nibble's code.
- R7: If enable falls after only one period, the encoder still emits 10001 and then 01101 followed by 00111.
- R8: `ser_o` carries the current group LSB first (`cg_o[0]` first), one bit per clock. `cg_stb_o` is high for exactly one cycle in every five, in the cycle in which `cg_o` takes a new value and `ser_o` shows bit 0. `cg_o` holds steady between strobes.
- R9: While `rst_ni` is low (asynchronous, active low), `cg_o` is 11111, `ser_o` is 1 and `cg_stb_o` is 1. The first cycle after release is a strobe cycle showing IDLE, and any frame in progress is abandoned.
- R10: Inputs are sampled only in the fifth bit cycle of a group, the cycle before the next strobe. Values held on the inputs in the earlier cycles of the period have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_en_i | input | 1 | Frame transmit enable |
| tx_er_i | input | 1 | Transmit error, forces HALT in data phase |
| txd_i | input | 4 | Transmit data nibble |
| cg_o | output | 5 | Current code-group |
| cg_stb_o | output | 1 | High in the first bit cycle of each code-group |
| ser_o | output | 1 | Serial code-group stream, LSB first |

## Verification
Several properties are checked on every cycle: the strobe spacing, the stability of `cg_o` between strobes, and the match between each serial bit and its parallel group. The ordering rules between successive groups are also checked each cycle: K always follows J, R always follows T, only IDLE or J follows IDLE or R, and HALT never starts a frame. Every emitted group must belong to the legal set. Some behaviour can only be shown by the bench's scenarios, which model the expected stream behaviourally and compare it group by group and bit by bit. That covers the exact data code chosen for each nibble, suppression of the preamble value and error during J/K, and the one-period frame. It also covers back-to-back frames, insensitivity to inputs outside the sampling cycle, and a reset in the middle of a frame.

// File: rtl/txenc_pkg.sv
package txenc_pkg;
  localparam int NIB_W = 4;
  localparam int CG_W  = 5;
  localparam int CNT_W = $clog2(CG_W);

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [CG_W-1:0]  cg_t;

  localparam cg_t CG_IDLE = 5'b11111;
  localparam cg_t CG_SSD1 = 5'b11000;
  localparam cg_t CG_SSD2 = 5'b10001;
  localparam cg_t CG_ESD1 = 5'b01101;
  localparam cg_t CG_ESD2 = 5'b00111;
  localparam cg_t CG_HALT = 5'b00100;

  typedef enum logic [2:0] {
    FS_IDLE, FS_SSD1, FS_SSD2, FS_DATA, FS_ESD1, FS_ESD2
  } fstate_t;

  function automatic cg_t nib_to_cg(input nib_t n);
    cg_t c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

  function automatic logic is_data_cg(input cg_t c);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < (1 << NIB_W); i++)
      if (nib_to_cg(nib_t'(i)) == c) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/txenc_bit_timer.sv
module txenc_bit_timer
  import txenc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  output logic first_o,
  output logic last_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CG_W - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == LAST);
endmodule

// File: rtl/txenc_frame_fsm.sv
module txenc_frame_fsm
  import txenc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic tx_en_i,
  input  logic tx_er_i,
  input  nib_t txd_i,
  output cg_t  cg_o,
  output cg_t  nxt_cg_o
);
  fstate_t st_q, st_d;
  cg_t     cg_q, cg_d;

  // state names the group last emitted; next group depends on it and enable
  always_comb begin
    st_d = st_q;
    cg_d = cg_q;
    case (st_q)
      FS_IDLE, FS_ESD2: begin
        if (tx_en_i) begin st_d = FS_SSD1; cg_d = CG_SSD1; end
        else         begin st_d = FS_IDLE; cg_d = CG_IDLE; end
      end
      FS_SSD1: begin st_d = FS_SSD2; cg_d = CG_SSD2; end
      FS_SSD2, FS_DATA: begin
        if (tx_en_i) begin
          st_d = FS_DATA;
          cg_d = tx_er_i ? CG_HALT : nib_to_cg(txd_i);
        end else begin
          st_d = FS_ESD1; cg_d = CG_ESD1;
        end
      end
      FS_ESD1: begin st_d = FS_ESD2; cg_d = CG_ESD2; end
      default: begin st_d = FS_IDLE; cg_d = CG_IDLE; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= FS_IDLE;
      cg_q <= CG_IDLE;
    end else if (tick_i) begin
      st_q <= st_d;
      cg_q <= cg_d;
    end
  end

  assign cg_o     = cg_q;
  assign nxt_cg_o = cg_d;
endmodule

// File: rtl/txenc_serializer.sv
module txenc_serializer #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] par_i,
  output logic         ser_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '1;
    else if (load_i) sh_q <= par_i;
    else             sh_q <= {1'b1, sh_q[W-1:1]};
  end

  assign ser_o = sh_q[0];
endmodule

// File: rtl/txenc_4b5b.sv
module txenc_4b5b
  import txenc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             tx_er_i,
  input  logic [NIB_W-1:0] txd_i,
  output logic [CG_W-1:0]  cg_o,
  output logic             cg_stb_o,
  output logic             ser_o
);
  logic first, last;
  cg_t  cur_cg, nxt_cg;

  txenc_bit_timer i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .first_o (first),
    .last_o  (last)
  );

  txenc_frame_fsm i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (last),
    .tx_en_i  (tx_en_i),
    .tx_er_i  (tx_er_i),
    .txd_i    (txd_i),
    .cg_o     (cur_cg),
    .nxt_cg_o (nxt_cg)
  );

  txenc_serializer #(.W(CG_W)) i_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (last),
    .par_i  (nxt_cg),
    .ser_o  (ser_o)
  );

  assign cg_o     = cur_cg;
  assign cg_stb_o = first;
endmodule

// File: rtl/txenc_4b5b_chk.sv
module txenc_4b5b_chk
  import txenc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CG_W-1:0]  cg_o,
  input logic             cg_stb_o,
  input logic             ser_o
);
  logic [CNT_W:0] gap_q;
  cg_t            prev_q;
  logic [CNT_W:0] idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      prev_q <= CG_IDLE;
    end else begin
      gap_q <= cg_stb_o ? (CNT_W+1)'(1) : gap_q + 1'b1;
      if (cg_stb_o) prev_q <= cg_o;
    end
  end

  assign idx = cg_stb_o ? '0 : gap_q;

  // R8
  stb_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cg_stb_o == (gap_q == '0 || gap_q == (CNT_W+1)'(CG_W)));

  // R8
  cg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cg_stb_o |-> $stable(cg_o));

  // R8
  ser_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx < (CNT_W+1)'(CG_W)) |-> ser_o == cg_o[idx]);

  // R1
  legal_cg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cg_stb_o |-> (is_data_cg(cg_o) || cg_o == CG_IDLE || cg_o == CG_SSD1 ||
                  cg_o == CG_SSD2 || cg_o == CG_ESD1 || cg_o == CG_ESD2 ||
                  cg_o == CG_HALT));

  // R2
  ssd_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cg_stb_o && prev_q == CG_SSD1) |-> cg_o == CG_SSD2);

  // R4
  esd_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cg_stb_o && prev_q == CG_ESD1) |-> cg_o == CG_ESD2);

  // R5
  idle_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cg_stb_o && (prev_q == CG_IDLE || prev_q == CG_ESD2)) |->
      (cg_o == CG_IDLE || cg_o == CG_SSD1));

  // R6
  halt_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cg_stb_o && cg_o == CG_HALT) |->
      (prev_q == CG_SSD2 || prev_q == CG_HALT || is_data_cg(prev_q)));
endmodule

bind txenc_4b5b txenc_4b5b_chk i_txenc_4b5b_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cg_o     (cg_o),
  .cg_stb_o (cg_stb_o),
  .ser_o    (ser_o)
);

// File: tb/test_txenc_4b5b.sv
module test_txenc_4b5b;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_en_i = 1'b0;
  logic       tx_er_i = 1'b0;
  logic [3:0] txd_i = 4'h0;
  logic [4:0] cg_o;
  logic       cg_stb_o;
  logic       ser_o;

  txenc_4b5b i_txenc_4b5b (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tx_en_i  (tx_en_i),
    .tx_er_i  (tx_er_i),
    .txd_i    (txd_i),
    .cg_o     (cg_o),
    .cg_stb_o (cg_stb_o),
    .ser_o    (ser_o)
  );

  always #4 clk_i = ~clk_i;

  int         checks = 0;
  int         errors = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] frm[$];
  bit         mon_en = 1'b0;
  bit         first = 1'b1;
  int         pos = 0;
  logic [4:0] cur_exp = 5'b11111;
  logic [4:0] ser_got = 5'b0;

  function automatic logic [4:0] code_of(input logic [3:0] n);
    logic [4:0] t[16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                          5'b01010, 5'b01011, 5'b01110, 5'b01111,
                          5'b10010, 5'b10011, 5'b10110, 5'b10111,
                          5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push(input logic [4:0] c, input string tag);
    exp_q.push_back(c);
    tag_q.push_back(tag);
  endtask

  // behavioural monitor: one group compare per strobe, serial compare per group
  always @(negedge clk_i) begin
    if (mon_en && rst_ni) begin
      if (cg_stb_o) begin
        logic [4:0] e;
        string t;
        if (!first) begin
          chk(pos == 5, "R8", "strobe spacing", pos, 5);
          chk(ser_got == cur_exp, "R8", "serial bits", int'(ser_got), int'(cur_exp));
        end
        first = 1'b0;
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
        end else begin
          e = 5'b11111;
          t = "R5";
        end
        chk(cg_o == e, t, "code-group", int'(cg_o), int'(e));
        cur_exp = e;
        pos = 0;
        ser_got = 5'b0;
      end
      if (!first) begin
        if (pos < 5) ser_got[pos] = ser_o;
        pos++;
      end
    end
  end

  // R10: junk on inputs for the first cycles of each period
  task automatic tick(input bit en, input bit er, input logic [3:0] d);
    @(negedge clk_i iff cg_stb_o);
    tx_en_i = ~en;
    tx_er_i = ~er;
    txd_i   = ~d;
    repeat (2) @(negedge clk_i);
    tx_en_i = en;
    tx_er_i = er;
    txd_i   = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) push(5'b11111, "R5");
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 4'(i));
  endtask

  task automatic send_frame(input int er_at, input bit pre_er, input int gap,
                            input string dtag);
    int    n;
    string ktag;
    n    = frm.size();
    ktag = (n == 1) ? "R7" : "R2";
    push(5'b11000, "R2");
    push(5'b10001, ktag);
    for (int i = 2; i < n; i++) begin
      if (i == er_at) push(5'b00100, "R6");
      else            push(code_of(frm[i]), dtag);
    end
    push(5'b01101, (n == 1) ? "R7" : "R4");
    push(5'b00111, (n == 1) ? "R7" : "R4");
    for (int i = 0; i < gap - ((n == 1) ? 3 : 2); i++) push(5'b11111, "R5");
    for (int i = 0; i < n; i++)
      tick(1'b1, (i == er_at) || (pre_er && i < 2), frm[i]);
    for (int i = 0; i < gap; i++) tick(1'b0, 1'b0, 4'(i + 3));
  endtask

  task automatic do_reset();
    mon_en  = 1'b0;
    tx_en_i = 1'b0;
    tx_er_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(cg_o == 5'b11111, "R9", "cg in reset", int'(cg_o), 31);
    chk(ser_o == 1'b1, "R9", "ser in reset", int'(ser_o), 1);
    chk(cg_stb_o == 1'b1, "R9", "stb in reset", int'(cg_stb_o), 1);
    repeat (3) @(negedge clk_i);
    exp_q.delete();
    tag_q.delete();
    push(5'b11111, "R9");
    @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    first  = 1'b1;
    pos    = 0;
    mon_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    idle(4);
    // R1: full table, preamble nibbles replaced (R2)
    frm = '{4'h5, 4'h5, 4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7,
            4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
    send_frame(-1, 1'b0, 3, "R1");
    // R6 halt, then back-to-back start right after ESD (R5)
    frm = '{4'h5, 4'h5, 4'hA, 4'hB, 4'hC, 4'hD};
    send_frame(3, 1'b0, 2, "R10");
    // R2: error during preamble ignored
    frm = '{4'h5, 4'h5, 4'h1, 4'h2};
    send_frame(-1, 1'b1, 4, "R3");
    // R7: one-period frame
    frm = '{4'h5};
    send_frame(-1, 1'b0, 3, "R7");
    // two-period frame
    frm = '{4'h5, 4'h5};
    send_frame(-1, 1'b0, 3, "R4");
    // arbitrary preamble values still become J/K
    frm = '{4'hE, 4'h3, 4'h7};
    send_frame(-1, 1'b0, 5, "R3");
    // R9: reset in the middle of a frame
    mon_en = 1'b0;
    tick(1'b1, 1'b0, 4'h5);
    tick(1'b1, 1'b0, 4'h5);
    tick(1'b1, 1'b0, 4'h9);
    do_reset();
    idle(2);
    frm = '{4'h5, 4'h5, 4'h9, 4'h8};
    send_frame(-1, 1'b0, 3, "R3");
    idle(3);
    repeat (2) @(negedge clk_i iff cg_stb_o);
    chk(exp_q.size() == 0, "R5", "all groups emitted", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule